// File: doc/BRIEF.md
# Tag-Only Set-Associative Hit Predictor

This block forecasts whether a memory access would be served from a set-associative cache or would have to go out to memory. It holds only the address tags of the lines a cache would contain, never the data. A timing model or a performance counter uses it to charge a fast or slow access. Each request carries an address and a read/write flag. The answer, hit or miss, appears exactly one clock after the request is accepted. Back-to-back requests are accepted every cycle once reset is over.

Three log2 parameters shape the tracker: total capacity, number of ways and line length. A 4 KiB data tracker is (12,2,5) and an 8 KiB instruction tracker is (13,2,5); both are 4-way with 32-byte lines. A one-entry memory of the most recently touched line answers repeats without a set search. Lines are installed only when a read misses, and the victim way comes from a round-robin pointer kept per set.

Top module: `tagcache_hit_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every tag is cleared to zero, every set pointer to way 0 and the last-line memory to a value no address can equal. `req_ready` and `rsp_valid` are 0 in the cycle after such an edge. `req_ready` is 1 from the first edge with `rst` low. Directly after reset, a read of 0xFFFFFFE0 is a miss.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) gives `rsp_valid`=1 for exactly the following cycle. With no accepted request, `rsp_valid` is 0 in the next cycle. `rsp_hit` is 0 whenever `rsp_valid` is 0.
- R3: The address splits into a line offset in bits [LINE_LG-1:0], a set index in the next SIZE_LG-WAYS_LG-LINE_LG bits, and a tag in all bits above. Addresses that differ only in the offset give the same answer.
- R4: After reset, a read whose tag field is zero hits in any set, because every stored tag is zero.
- R5: A request to the same line as the most recent hit or read allocation hits, whatever its direction.
- R6: A read that misses writes its tag into the way named by that set's pointer. It advances the pointer by one modulo the way count and reports a miss. A later read of the line hits while the line stays resident.
- R7: With all ways of a set filled by misses, the next read miss to that set replaces the line that was allocated earliest. The other lines still hit.
- R8: Allocation in one set changes neither the tags nor the pointer of any other set.
- R9: A write that misses reports a miss and changes nothing. A following read of the same line misses, and the set's eviction order is unchanged.
- R10: A write that matches a resident tag reports a hit and installs nothing.
- R11: Hits do not move a set's pointer. The eviction order depends only on the sequence of read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Tracker can take a request this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Answer for the request accepted at the previous edge |
| rsp_hit | output | 1 | 1 for hit, 0 for miss; valid with `rsp_valid` |

## Verification
Two things can land on the same edge: a read miss installs a tag and moves the last-line memory, and the next request is looked up against that just-changed state. The bench provokes this with back-to-back streams. A miss is followed at once by a repeat of the same line, by a different line of the same set, or by the read that triggers eviction in a set that has just been filled. Every answer is compared with a scoreboard model that applies the requests strictly in order. A design that uses stale state for the second request is therefore caught.

// File: rtl/thit_pkg.sv
package thit_pkg;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_dir_e;

   // outcome of a single lookup before it is registered
   typedef struct packed {
      logic hit;
      logic fill;
      logic touch;
   } lookup_res_t;

   function automatic int ptr_width(input int ways_lg);
      return (ways_lg > 0) ? ways_lg : 1;
   endfunction

endpackage

// File: rtl/thit_addr_split.sv
module thit_addr_split #(
   parameter int ADDR_W  = 32,
   parameter int LINE_LG = 5,
   parameter int IDX_W   = 5,
   localparam int TAG_W  = ADDR_W - LINE_LG - IDX_W,
   localparam int LN_W   = ADDR_W - LINE_LG
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag,
   output logic [LN_W-1:0]   line
);

   logic offs_unused;

   assign idx         = addr[LINE_LG +: IDX_W];
   assign tag         = addr[ADDR_W-1 -: TAG_W];
   assign line        = addr[ADDR_W-1:LINE_LG];
   assign offs_unused = ^addr[LINE_LG-1:0];

endmodule

// File: rtl/thit_way_match.sv
module thit_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 22
) (
   input  logic                       en,
   input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
   input  logic [TAG_W-1:0]           probe,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w] = en && (set_tags[w] == probe);
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/thit_set_store.sv
module thit_set_store #(
   parameter int SETS   = 32,
   parameter int WAYS   = 4,
   parameter int TAG_W  = 22,
   localparam int IDX_W = $clog2(SETS),
   localparam int PTR_W = thit_pkg::ptr_width($clog2(WAYS))
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
   input  logic                       fill_en,
   input  logic [IDX_W-1:0]           fill_idx,
   input  logic [TAG_W-1:0]           fill_tag
);

   logic [WAYS-1:0][TAG_W-1:0] set_view [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [WAYS-1:0][TAG_W-1:0] tag_q;
      logic                       sel;

      assign sel         = fill_en && (fill_idx == IDX_W'(s));
      assign set_view[s] = tag_q;

      if (WAYS == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst) begin
               tag_q <= '0;
            end else if (sel) begin
               tag_q[0] <= fill_tag;
            end
         end
      end else begin : g_assoc
         logic [PTR_W-1:0] ptr_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               tag_q <= '0;
               ptr_q <= '0;
            end else if (sel) begin
               tag_q[ptr_q] <= fill_tag;
               ptr_q        <= ptr_q + PTR_W'(1);
            end
         end
      end
   end

   assign rd_tags = set_view[rd_idx];

endmodule

// File: rtl/tagcache_hit_tracker.sv
module tagcache_hit_tracker #(
   parameter int ADDR_W  = 32,
   parameter int SIZE_LG = 12,
   parameter int WAYS_LG = 2,
   parameter int LINE_LG = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic              rsp_hit
);
   import thit_pkg::*;

   localparam int IDX_W = SIZE_LG - WAYS_LG - LINE_LG;
   localparam int SETS  = 1 << IDX_W;
   localparam int WAYS  = 1 << WAYS_LG;
   localparam int TAG_W = ADDR_W - LINE_LG - IDX_W;
   localparam int LN_W  = ADDR_W - LINE_LG;

   if (IDX_W < 1) begin : g_chk_idx
      $error("tagcache_hit_tracker: capacity must exceed one line per way");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("tagcache_hit_tracker: address too narrow for the geometry");
   end
   if (WAYS_LG < 0 || LINE_LG < 1) begin : g_chk_geom
      $error("tagcache_hit_tracker: bad way or line parameter");
   end

   logic                       ready_q;
   logic                       acc;
   logic [IDX_W-1:0]           idx;
   logic [TAG_W-1:0]           tag;
   logic [LN_W-1:0]            line;
   logic [LN_W:0]              last_q;
   logic                       same_line;
   logic [WAYS-1:0][TAG_W-1:0] set_tags;
   logic [WAYS-1:0]            way_hits;
   logic                       search_hit;
   lookup_res_t                res;
   acc_dir_e                   dir;

   assign acc = req_valid && ready_q;
   assign dir = acc_dir_e'(req_write);

   thit_addr_split #(
      .ADDR_W (ADDR_W),
      .LINE_LG(LINE_LG),
      .IDX_W  (IDX_W)
   ) u_split (
      .addr(req_addr),
      .idx (idx),
      .tag (tag),
      .line(line)
   );

   // guard bit: reset value can never equal a real line number
   assign same_line = (last_q == {1'b0, line});

   thit_set_store #(
      .SETS (SETS),
      .WAYS (WAYS),
      .TAG_W(TAG_W)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .rd_idx  (idx),
      .rd_tags (set_tags),
      .fill_en (res.fill),
      .fill_idx(idx),
      .fill_tag(tag)
   );

   thit_way_match #(
      .WAYS (WAYS),
      .TAG_W(TAG_W)
   ) u_match (
      .en      (acc && !same_line),
      .set_tags(set_tags),
      .probe   (tag),
      .hit_vec (way_hits),
      .hit     (search_hit)
   );

   always_comb begin
      res.hit   = acc && (same_line || search_hit);
      res.fill  = acc && !res.hit && (dir == ACC_READ);
      res.touch = acc && (search_hit || res.fill);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q   <= 1'b0;
         last_q    <= '1;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
      end else begin
         ready_q   <= 1'b1;
         rsp_valid <= acc;
         rsp_hit   <= res.hit;
         if (res.touch) begin
            last_q <= {1'b0, line};
         end
      end
   end

   assign req_ready = ready_q;

endmodule

// File: rtl/thit_checker.sv
module thit_checker #(
   parameter int ADDR_W  = 32,
   parameter int LINE_LG = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              rsp_valid,
   input logic              rsp_hit
);

   logic                     prev_acc;
   logic                     prev_wr;
   logic [ADDR_W-LINE_LG-1:0] prev_line;
   logic                     acc;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_acc  <= 1'b0;
         prev_wr   <= 1'b0;
         prev_line <= '0;
      end else begin
         prev_acc  <= acc;
         prev_wr   <= req_write;
         prev_line <= req_addr[ADDR_W-1:LINE_LG];
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!req_ready && !rsp_valid));

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
      acc |=> rsp_valid);

   assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
      !acc |=> !rsp_valid);

   assert_hit_qualified_R2: assert property (@(posedge clk) disable iff (rst)
      !rsp_valid |-> !rsp_hit);

   // previous request installed or matched this line, so it must hit now
   assert_repeat_hits_R5: assert property (@(posedge clk) disable iff (rst)
      (acc && prev_acc && (req_addr[ADDR_W-1:LINE_LG] == prev_line)
       && (!prev_wr || rsp_hit)) |=> rsp_hit);

endmodule

bind tagcache_hit_tracker thit_checker #(
   .ADDR_W (ADDR_W),
   .LINE_LG(LINE_LG)
) u_thit_chk (
   .clk      (clk),
   .rst      (rst),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_addr (req_addr),
   .req_write(req_write),
   .rsp_valid(rsp_valid),
   .rsp_hit  (rsp_hit)
);

// File: tb/tagcache_hit_tracker_bench.sv
module tagcache_hit_tracker_bench;

   localparam int ADDR_W = 32;
   localparam int SETS   = 32;
   localparam int WAYS   = 4;
   localparam int TAG_W  = 22;

   typedef struct {
      bit    hit;
      string req;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic              rsp_valid;
   logic              rsp_hit;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;
   exp_t exp_q[$];

   // scoreboard model
   logic [TAG_W-1:0] m_tag [SETS][WAYS];
   int               m_ptr [SETS];
   logic [26:0]      m_last;
   bit               m_last_ok;

   always #2 clk = ~clk;

   tagcache_hit_tracker u_tagcache_hit_tracker (
      .clk      (clk),
      .rst      (rst),
      .req_valid(req_valid),
      .req_ready(req_ready),
      .req_addr (req_addr),
      .req_write(req_write),
      .rsp_valid(rsp_valid),
      .rsp_hit  (rsp_hit)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < SETS; s++) begin
         m_ptr[s] = 0;
         for (int w = 0; w < WAYS; w++) m_tag[s][w] = '0;
      end
      m_last_ok = 1'b0;
      m_last    = '0;
   endtask

   function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
      return {tag[TAG_W-1:0], set[4:0], off[4:0]};
   endfunction

   task automatic send(input logic [ADDR_W-1:0] a, input bit wr, input string req);
      logic [26:0]      ln;
      int               s;
      logic [TAG_W-1:0] t;
      bit               h;
      exp_t             e;
      ln = a[31:5];
      s  = int'(a[9:5]);
      t  = a[31:10];
      h  = 1'b0;
      if (m_last_ok && m_last == ln) begin
         h = 1'b1;
      end else begin
         for (int w = 0; w < WAYS; w++) if (m_tag[s][w] == t) h = 1'b1;
         if (h) begin
            m_last = ln; m_last_ok = 1'b1;
         end else if (!wr) begin
            m_tag[s][m_ptr[s]] = t;
            m_ptr[s] = (m_ptr[s] + 1) % WAYS;
            m_last = ln; m_last_ok = 1'b1;
         end
      end
      e.hit = h;
      e.req = req;
      exp_q.push_back(e);
      req_valid = 1'b1;
      req_addr  = a;
      req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: outputs are registered, so look at them between edges
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
               check("R2 unexpected response", 1'b1, 1'b0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(e.req, rsp_hit, e.hit);
            end
         end
      end
   end

   task automatic drain();
      repeat (3) @(negedge clk);
      check("R2 all responses returned", exp_q.size() == 0, 1'b1);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 ready low in reset", req_ready, 1'b0);
      check("R1 rsp_valid low in reset", rsp_valid, 1'b0);
      rst = 1'b0;
      model_reset();
      @(negedge clk);
      check("R1 ready after reset", req_ready, 1'b1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();

      // R1: last-line memory cannot match the top line
      send(32'hFFFF_FFE0, 1'b0, "R1 top line after reset misses");
      send(32'hFFFF_FFE4, 1'b0, "R5 top line repeat hits");
      drain();
      do_reset();

      // R4: tag zero hits after reset, R3 offset ignored
      send(mk(0, 2, 0), 1'b0, "R4 zero tag hits");
      send(mk(0, 9, 8), 1'b1, "R4 zero tag write hits");
      send(mk(0, 2, 31), 1'b0, "R3 offset does not matter");

      // R6/R7: fill set 3, then evict in order (back to back)
      send(mk(1, 3, 0), 1'b0, "R6 first fill misses");
      send(mk(1, 3, 4), 1'b0, "R5 same line right after fill");
      send(mk(2, 3, 0), 1'b0, "R6 second fill");
      send(mk(3, 3, 0), 1'b0, "R6 third fill");
      send(mk(4, 3, 0), 1'b0, "R6 fourth fill");
      send(mk(1, 3, 0), 1'b0, "R6 first line resident");
      send(mk(2, 3, 8), 1'b0, "R11 hit keeps pointer");
      send(mk(5, 3, 0), 1'b0, "R7 fifth tag evicts oldest");
      send(mk(1, 3, 0), 1'b0, "R7 oldest line gone");
      send(mk(3, 3, 0), 1'b0, "R7 newer line kept");
      send(mk(2, 3, 0), 1'b0, "R7 second oldest evicted");
      send(mk(4, 3, 0), 1'b0, "R7 fourth still present");

      // R8: neighbouring set untouched
      send(mk(1, 4, 0), 1'b0, "R8 other set independent miss");
      send(mk(5, 3, 0), 1'b0, "R8 set 3 unchanged");
      send(mk(0, 4, 0), 1'b0, "R8 other set zero tags intact");

      // R9: write miss allocates nothing
      send(mk(9, 7, 0), 1'b1, "R9 write miss");
      send(mk(9, 7, 0), 1'b0, "R9 read after write miss misses");
      send(mk(9, 7, 0), 1'b0, "R9 read allocation then hits");
      send(mk(6, 8, 0), 1'b1, "R9 write miss set 8");
      send(mk(1, 8, 0), 1'b0, "R9 fill set 8 way 0");
      send(mk(2, 8, 0), 1'b0, "R9 fill set 8 way 1");
      send(mk(3, 8, 0), 1'b0, "R9 fill set 8 way 2");
      send(mk(4, 8, 0), 1'b0, "R9 fill set 8 way 3");
      send(mk(5, 8, 0), 1'b0, "R9 evicts first read fill");
      send(mk(2, 8, 0), 1'b0, "R9 order unaffected by write");

      // R10: write hit reports hit without allocation
      send(mk(3, 8, 0), 1'b1, "R10 write hit");
      send(mk(7, 8, 0), 1'b1, "R10 write miss after hit");
      send(mk(7, 8, 0), 1'b0, "R10 no install from write");

      // idle gap then repeat
      repeat (2) @(negedge clk);
      send(mk(7, 8, 12), 1'b0, "R5 repeat after idle gap");
      send(mk(4, 8, 0), 1'b0, "R7 pointer order continues");

      drain();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule